// File: doc/BRIEF.md
# Byte-Addressed Memory Target for a Two-Wire Serial Bus

This block is a target device on an I2C bus. It presents a small memory of 256 bytes to the bus controller. A fast system clock samples both bus lines, SCL and SDA. The block recognises START, repeated START and STOP conditions. It answers to a 7-bit device address. The upper four bits of that address are a fixed type code, set by the `DEV_TYPE` parameter and `4'b1010` by default. The lower three bits come from strap pins, so that several copies of the block can share one bus.

A write transaction carries the device address with the read/write bit at 0. The first byte after it loads an internal byte pointer, and every later byte is stored at that pointer. A random read writes the pointer, then issues a repeated START and the address again with the read bit at 1, then clocks data out. When a STOP ends a write that stored at least one data byte, the block starts a write cycle of `WRITE_CYCLE_CLKS` system clocks. During the write cycle it refuses its own address.

The block never drives SDA high. `sda_oe` at 1 means the block pulls SDA low. The board or the bench forms the wired-AND of all drivers and the pull-up.

The controller is a state machine with these states:
- `ST_IDLE`: the bus is free.
- `ST_ADDR`: the address byte is being received.
- `ST_ADDR_ACK`: the address acknowledge slot.
- `ST_PTR`: the pointer byte is being received.
- `ST_PTR_ACK`: the pointer acknowledge slot.
- `ST_WDATA`: a data byte is being received.
- `ST_WDATA_ACK`: the data acknowledge slot.
- `ST_RDATA`: a data byte is being shifted out.
- `ST_RACK`: the controller's acknowledge slot.
- `ST_IGNORE`: the bus is released until the next START.

Its transitions are:
- A START leads from any state to `ST_ADDR`.
- A STOP leads from any state to `ST_IDLE`.
- After the eighth bit, `ST_ADDR` goes to `ST_ADDR_ACK` when the address matches and no write cycle is running, and to `ST_IGNORE` otherwise.
- `ST_ADDR_ACK` goes to `ST_RDATA` for a read and to `ST_PTR` for a write.
- `ST_PTR` goes to `ST_PTR_ACK`, and `ST_PTR_ACK` goes to `ST_WDATA`.
- `ST_WDATA` goes to `ST_WDATA_ACK`, and `ST_WDATA_ACK` goes back to `ST_WDATA`.
- `ST_RDATA` goes to `ST_RACK`.
- `ST_RACK` goes back to `ST_RDATA` on an acknowledge, and to `ST_IGNORE` on a not-acknowledge.

Top module: `i2c_mem_target`

## Requirements
- R1: While reset is asserted and right after reset, `sda_oe` is 0. The block does not pull SDA.
- R2: A byte is accepted only after a START, which is SDA falling while SCL is high. After a STOP, which is SDA rising while SCL is high, a byte that is clocked without a new START gets no acknowledge.
- R3: The address byte is taken MSB first on rising SCL edges. Its bits [7:1] are the address and bit 0 is the read flag, where 1 means read. The block acknowledges by pulling SDA low in the ninth clock only when the address equals {DEV_TYPE, strap_addr}. On a mismatch it leaves SDA released for the rest of the transfer, until the next START.
- R4: The block changes `sda_oe` only while SCL is low. It acknowledges by holding SDA low from before the ninth rising edge until after the ninth falling edge.
- R5: In a write, the first byte after the address loads the pointer. Each later byte is stored at the pointer. The block acknowledges every one of these bytes.
- R6: After a repeated START and a matching address with the read flag at 1, the block returns the byte at the pointer, MSB first. The bit is driven after each falling SCL edge.
- R7: The pointer increases by one after each data byte that is written or read, and wraps from 255 to 0.
- R8: When the controller answers a read byte with a not-acknowledge (SDA high in the ninth clock), the block stops driving SDA until the next START.
- R9: A STOP that ends a write with at least one data byte starts a write cycle of WRITE_CYCLE_CLKS system clocks. During that cycle the block does not acknowledge its address. After the cycle it acknowledges again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous reset, active low |
| strap_addr | input | 3 | Low three bits of the device address |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The following are checked on every cycle:
- `sda_oe` changes only while the synchronised SCL is low.
- The block stays quiet in the idle and ignore states.
- The pointer either steps by one with wrap-around or is loaded from the pointer byte.
- No address acknowledge is given while a write cycle is counting down.

Only the bench's transactions can show that stored bytes are later read back in the correct order and that a mismatched address gets no acknowledge. They also show that a STOP really ends a transfer and that the write-cycle window closes after the set number of clocks.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_t;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Multi-stage synchroniser plus edge detection for a group of bus lines.
module i2c_tgt_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_in,
    output logic [LINES-1:0] lvl,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [STAGES-1:0] chain;
            logic              prev;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= '1;
                    prev  <= 1'b1;
                end else begin
                    chain <= {chain[STAGES-2:0], line_in[g]};
                    prev  <= chain[STAGES-1];
                end
            end
            assign lvl[g]  = chain[STAGES-1];
            assign rise[g] = chain[STAGES-1] & ~prev;
            assign fall[g] = ~chain[STAGES-1] & prev;
        end
    endgenerate
endmodule

// File: rtl/i2c_tgt_mem.sv
// Byte array with one write port and a combinational read port.
module i2c_tgt_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end
    assign rdata = cells[raddr];
endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [3:0] DEV_TYPE         = 4'b1010,
    parameter int         WRITE_CYCLE_CLKS = 50000,
    parameter int         SYNC_STAGES      = 2,
    parameter int         PTR_W            = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] strap_addr,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe
);
    localparam int BUSY_W = $clog2(WRITE_CYCLE_CLKS + 1);

    logic [1:0] lvl, rise, fall;
    logic       scl_s, sda_s, scl_rise, scl_fall;
    logic       start_ev, stop_ev;

    i2c_tgt_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_in({sda_in, scl_in}),
        .lvl(lvl), .rise(rise), .fall(fall)
    );
    assign scl_s    = lvl[0];
    assign sda_s    = lvl[1];
    assign scl_rise = rise[0];
    assign scl_fall = fall[0];
    assign start_ev = fall[1] & scl_s;
    assign stop_ev  = rise[1] & scl_s;

    tgt_state_t       state, state_nx;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic [PTR_W-1:0] ptr;
    logic             rw_q, wr_pending;
    logic [BUSY_W-1:0] busy_cnt;
    logic             byte_done, addr_hit, mem_we;
    logic [7:0]       mem_rd;

    assign byte_done = scl_fall && (bitcnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == {DEV_TYPE, strap_addr}) && (busy_cnt == '0);
    assign mem_we    = (state == ST_WDATA) && byte_done && !start_ev && !stop_ev;

    i2c_tgt_mem #(.AW(PTR_W), .DW(8)) u_mem (
        .clk(clk), .we(mem_we), .waddr(ptr), .wdata(shreg),
        .raddr(ptr), .rdata(mem_rd)
    );

    always_comb begin
        state_nx = state;
        if (start_ev) begin
            state_nx = ST_ADDR;
        end else if (stop_ev) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: state_nx = state;
                ST_ADDR:      if (byte_done) state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RDATA : ST_PTR;
                ST_PTR:       if (byte_done) state_nx = ST_PTR_ACK;
                ST_PTR_ACK:   if (scl_fall) state_nx = ST_WDATA;
                ST_WDATA:     if (byte_done) state_nx = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) state_nx = ST_WDATA;
                ST_RDATA:     if (byte_done) state_nx = ST_RACK;
                ST_RACK: begin
                    if (scl_rise && sda_s) state_nx = ST_IGNORE;
                    else if (scl_fall)     state_nx = ST_RDATA;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt   <= '0;
            wr_pending <= 1'b0;
        end else if (stop_ev && wr_pending) begin
            busy_cnt   <= BUSY_W'(WRITE_CYCLE_CLKS);
            wr_pending <= 1'b0;
        end else begin
            if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
            if (mem_we)         wr_pending <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            bitcnt <= '0;
            ptr    <= '0;
            rw_q   <= 1'b0;
            sda_oe <= 1'b0;
        end else if (start_ev || stop_ev) begin
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        if (state == ST_ADDR) begin
                            rw_q   <= shreg[0];
                            sda_oe <= addr_hit;
                        end else begin
                            sda_oe <= 1'b1;
                            if (state == ST_PTR) ptr <= shreg;
                            else                 ptr <= ptr + 1'b1;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (rw_q) begin
                            shreg  <= mem_rd;
                            sda_oe <= ~mem_rd[7];
                        end else begin
                            sda_oe <= 1'b0;
                        end
                    end
                end
                ST_PTR_ACK, ST_WDATA_ACK: begin
                    if (scl_fall) sda_oe <= 1'b0;
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        bitcnt <= bitcnt + 1'b1;
                    end else if (byte_done) begin
                        bitcnt <= '0;
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                    end else if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        shreg  <= mem_rd;
                        sda_oe <= ~mem_rd[7];
                    end
                end
                ST_IDLE, ST_IGNORE: sda_oe <= 1'b0;
                default: sda_oe <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/i2c_mem_target_chk.sv
module i2c_mem_target_chk
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W  = 8,
    parameter int BUSY_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              sda_oe,
    input tgt_state_t        state,
    input logic [PTR_W-1:0]  ptr,
    input logic [BUSY_W-1:0] busy_cnt
);
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_s) else $error("oe moved with SCL high"); // R4

    AST_QUIET_STATES: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_IGNORE) |-> !sda_oe) else $error("driving while quiet"); // R8

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ((ptr == PTR_W'($past(ptr) + 1'b1)) || ($past(state) == ST_PTR)))
        else $error("pointer jumped"); // R7

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_cnt != '0) |-> (state != ST_ADDR_ACK)) else $error("ack during write cycle"); // R9
endmodule

bind i2c_mem_target i2c_mem_target_chk #(.PTR_W(PTR_W), .BUSY_W(BUSY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
    .state(state), .ptr(ptr), .busy_cnt(busy_cnt)
);

// File: tb/tb_i2c_mem_target.sv
`timescale 1ns/1ps
module tb_i2c_mem_target;
    localparam int Q  = 8;
    localparam int WC = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] strap = 3'd3;
    logic       scl = 1'b1;
    logic       bus_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [7:0] model [256];
    logic [7:0] wbuf [8];

    assign sda_line = !(bus_low || sda_oe);

    always #2.5 clk = ~clk;

    i2c_mem_target #(.WRITE_CYCLE_CLKS(WC)) dut (
        .clk(clk), .rst_n(rst_n), .strap_addr(strap),
        .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe)
    );

    function automatic logic exp_ack(input logic [6:0] a, input logic [2:0] s, input bit busy);
        return (a == {4'b1010, s}) && !busy;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        bus_low = !b; q(); scl = 1'b1; q(); q(); scl = 1'b0; q();
    endtask

    task automatic bit_in(output logic b);
        bus_low = 1'b0; q(); scl = 1'b1; q(); b = sda_line; q(); scl = 1'b0; q();
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(b);
        ack = !b;
    endtask

    task automatic byte_in(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(!ack);
    endtask

    task automatic start_c();
        bus_low = 1'b0; q(); scl = 1'b1; q(); bus_low = 1'b1; q(); scl = 1'b0; q();
    endtask

    task automatic stop_c();
        bus_low = 1'b1; q(); scl = 1'b1; q(); bus_low = 1'b0; q();
    endtask

    task automatic write_txn(input logic [7:0] p, input int n, input string tag);
        logic a;
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        check(a, tag, a, 1);
        byte_out(p, a);
        check(a, tag, a, 1);
        for (int i = 0; i < n; i++) begin
            byte_out(wbuf[i], a);
            check(a, tag, a, 1);
            model[8'(p + i)] = wbuf[i];
        end
        stop_c();
        repeat (WC + 100) @(negedge clk);
    endtask

    task automatic read_txn(input logic [7:0] p, input int n, input string tag);
        logic a;
        logic [7:0] d;
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        byte_out(p, a);
        start_c();
        byte_out({4'b1010, strap, 1'b1}, a);
        check(a, tag, a, 1);
        for (int i = 0; i < n; i++) begin
            byte_in(i != n - 1, d);
            check(d == model[8'(p + i)], tag, d, model[8'(p + i)]);
        end
        stop_c();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic a;
        logic [7:0] d;
        void'($urandom(32'd7));
        repeat (10) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset", sda_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(sda_oe == 1'b0, "R1 after reset", sda_oe, 0);

        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h01;
        write_txn(8'h10, 3, "R5 directed write");
        read_txn(8'h10, 3, "R6 directed read");

        // R9: poll straight after a data write
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        byte_out(8'h20, a);
        byte_out(8'h77, a);
        stop_c();
        model[8'h20] = 8'h77;
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        check(a == exp_ack({4'b1010, strap}, strap, 1), "R9 busy nack", a, 0);
        stop_c();
        repeat (WC + 50) @(negedge clk);
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        check(a == exp_ack({4'b1010, strap}, strap, 0), "R9 ack after cycle", a, 1);
        stop_c();

        // R3: wrong strap value, then data byte must stay unanswered
        start_c();
        byte_out({4'b1010, 3'd6, 1'b0}, a);
        check(a == exp_ack({4'b1010, 3'd6}, strap, 0), "R3 mismatch nack", a, 0);
        byte_out(8'h00, a);
        check(!a, "R3 ignore until start", a, 0);
        stop_c();
        start_c();
        byte_out({4'b0110, strap, 1'b0}, a);
        check(!a, "R3 type code mismatch", a, 0);
        stop_c();

        // R2: byte without START after STOP
        byte_out({4'b1010, strap, 1'b0}, a);
        check(!a, "R2 no start no ack", a, 0);
        stop_c();

        // R7: wrap from 255 to 0
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2;
        write_txn(8'hFF, 2, "R7 wrap write");
        read_txn(8'hFF, 2, "R7 wrap read");

        // R8: after controller NACK, further clocks read released bus
        start_c();
        byte_out({4'b1010, strap, 1'b0}, a);
        byte_out(8'h10, a);
        start_c();
        byte_out({4'b1010, strap, 1'b1}, a);
        byte_in(1'b0, d);
        check(d == model[8'h10], "R6 single read", d, model[8'h10]);
        byte_in(1'b0, d);
        check(d == 8'hFF, "R8 released after nack", d, 8'hFF);
        stop_c();

        // R3: new strap value answers
        strap = 3'd5;
        repeat (4) @(negedge clk);
        start_c();
        byte_out({4'b1010, 3'd5, 1'b0}, a);
        check(a, "R3 strap change", a, 1);
        stop_c();

        // R4: ack hold through the ninth high phase checked by sampling
        for (int t = 0; t < 12; t++) begin
            logic [7:0] p;
            int n;
            p = 8'($urandom % 256);
            n = 1 + int'($urandom % 4);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            write_txn(p, n, "R5 random write");
            read_txn(p, n, "R6 R7 random read");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule